// File: doc/BRIEF.md
# Serial Transmit Handshake Controller

This block runs the transmit half of an asynchronous serial port. A processor writes one character at a time over a byte-wide write strobe. The block takes the character only while its empty flag is up. It turns the character into a frame on a single line, and it advances the frame one bit for each strobe it receives from an external baud divider.

Two status flags report progress: an empty flag, meaning a new character may be written, and a complete flag, meaning the line has gone idle. Both drop when a frame starts and rise together when it ends. A single interrupt request combines the two flags with their enables. A mode input selects the short frame (10 bit periods) or the long frame (11 bit periods).

Top module: `sertx_ctrl`

## Requirements
- R1: After reset the line is high (idle), the empty and complete flags are both 1, and no character is pending, so raising the enable alone starts no frame.
- R2: A write strobe while the empty flag is 0 is discarded: that character never appears on the line and does not replace the stored one.
- R3: When the transmit enable is 1, no frame is in progress and a character is pending or is being accepted in the same cycle, then in the next cycle the empty and complete flags are both 0 and the line is low (start bit).
- R4: The frame is a low start bit, then the data bits least significant first, then high bits. With mode 0 the frame is 10 bit periods long with one high bit. With mode 1 it is 11 bit periods long with two high bits. The mode is sampled when the frame starts.
- R5: While a frame is in progress the line changes only in the cycle after a bit strobe, and each strobe advances it by exactly one bit. A strobe in the cycle the frame starts is not counted.
- R6: The frame ends on the last counted strobe. In the next cycle both flags are 1 and the line is high.
- R7: A character written while the enable is 0 stays pending, and its frame starts once the enable is 1. A later write before that start replaces it.
- R8: The interrupt request is 1 exactly when (transmit-interrupt enable and empty flag) or (complete-interrupt enable and complete flag).
- R9: Clearing the enable during a frame lets that frame run to its end but starts no further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | DATA_W | Character to send |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | Frame mode: 0 = 10 periods, 1 = 11 periods |
| tie | input | 1 | Interrupt enable for the empty flag |
| tcie | input | 1 | Interrupt enable for the complete flag |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| txd | output | 1 | Serial line, idles high |
| tx_empty | output | 1 | Ready to accept a character |
| tx_done | output | 1 | No frame in progress |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
A wrong pending mark shows up as a frame that starts when no write was accepted, or as no frame after a write. Either one is visible on the flags one cycle after the enable and the pending state meet. A wrong bit counter moves the rising edge of the flags earlier or later by whole bit periods, and it shifts or cuts off the high bits at the end of the frame. A bad shift register shows a wrong line level in the cycle after a strobe. The bench compares every cycle, so each of these faults is caught in the first cycle where the line or a flag differs from the reference.

// File: rtl/sertx_ctrl.sv
module sertx_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              tie,
  input  logic              tcie,
  input  logic              bit_tick,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done,
  output logic              tx_irq
);
  localparam int SH_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(DATA_W + 4);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(DATA_W + 3);

  logic [DATA_W-1:0] hold;
  logic              pending, busy;
  logic [SH_W-1:0]   shreg;
  logic [CNT_W-1:0]  left;

  wire accept = wr_en & tx_empty;
  wire start  = tx_en & ~busy & (pending | accept);
  wire [DATA_W-1:0] next_char = accept ? wr_data : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= '0;
      pending  <= 1'b0;
      busy     <= 1'b0;
      shreg    <= '1;
      left     <= '0;
      tx_empty <= 1'b1;
      tx_done  <= 1'b1;
    end else begin
      if (accept) begin
        hold    <= wr_data;
        pending <= 1'b1;
      end
      if (start) begin
        pending  <= 1'b0;
        busy     <= 1'b1;
        tx_empty <= 1'b0;
        tx_done  <= 1'b0;
        shreg    <= {2'b11, next_char, 1'b0};
        left     <= nine_bit ? LEN_LONG : LEN_SHORT;
      end else if (busy && bit_tick) begin
        shreg <= {1'b1, shreg[SH_W-1:1]};
        left  <= left - 1'b1;
        if (left == CNT_W'(1)) begin
          busy     <= 1'b0;
          tx_empty <= 1'b1;
          tx_done  <= 1'b1;
        end
      end
    end
  end

  assign txd    = busy ? shreg[0] : 1'b1;
  assign tx_irq = (tie & tx_empty) | (tcie & tx_done);
endmodule

// File: rtl/sertx_ctrl_chk.sv
module sertx_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic bit_tick,
  input logic txd,
  input logic tx_empty,
  input logic tx_done,
  input logic tx_irq
);
  AST_FLAGS_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty == tx_done); // R6
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> !txd); // R3
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(tx_en)); // R3
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $past(bit_tick)); // R6
  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && $past(!tx_empty) && !$past(bit_tick)) |-> $stable(txd)); // R5
  AST_NO_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && !tx_done) |-> !tx_irq); // R8
endmodule

bind sertx_ctrl sertx_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_tick(bit_tick),
  .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .tx_irq(tx_irq)
);

// File: tb/sertx_ctrl_bench.sv
module sertx_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, tx_en = 1'b0, nine_bit = 1'b0, tie = 1'b0, tcie = 1'b0, bit_tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, tx_empty, tx_done, tx_irq;
  int checks = 0, errors = 0, tick_div = 4, tick_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sertx_ctrl u_sertx_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_en(tx_en),
    .nine_bit(nine_bit), .tie(tie), .tcie(tcie), .bit_tick(bit_tick),
    .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done), .tx_irq(tx_irq));

  // Reference model: a queue of line levels still to be sent
  bit m_empty = 1, m_pend = 0, m_busy = 0;
  bit [7:0] m_hold = 0;
  bit m_line[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_empty = 1; m_pend = 0; m_busy = 0; m_hold = 0; m_line = {};
    end else begin
      bit acc, st, was_busy;
      bit [7:0] ch;
      acc = wr_en && m_empty;
      was_busy = m_busy;
      st = tx_en && !was_busy && (m_pend || acc);
      ch = acc ? wr_data : m_hold;
      if (acc) begin m_hold = wr_data; m_pend = 1; end
      if (st) begin
        m_pend = 0; m_busy = 1; m_empty = 0; m_line = {};
        m_line.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_line.push_back(ch[i]);
        m_line.push_back(1'b1);
        if (nine_bit) m_line.push_back(1'b1);
      end else if (was_busy && bit_tick) begin
        void'(m_line.pop_front());
        if (m_line.size() == 0) begin m_busy = 0; m_empty = 1; end
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R3 R4 R5 txd", txd, m_busy ? m_line[0] : 1'b1);
      chk("R2 R3 R6 R7 R9 empty", tx_empty, m_empty);
      chk("R3 R6 done", tx_done, m_empty);
      chk("R8 irq", tx_irq, (tie && m_empty) || (tcie && m_empty));
    end
  end

  always @(negedge clk) begin
    tick_cnt = tick_cnt + 1;
    if (tick_cnt >= tick_div) begin tick_cnt = 0; bit_tick <= 1'b1; end
    else bit_tick <= 1'b0;
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en <= 1'b1; wr_data <= d;
    @(negedge clk); wr_en <= 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tx_empty) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    chk("R1 reset txd", txd, 1'b1);
    chk("R1 reset empty", tx_empty, 1'b1);
    chk("R1 reset done", tx_done, 1'b1);
    tx_en <= 1'b1; tie <= 1'b1;
    repeat (12) @(negedge clk);
    chk("R1 nothing pending", tx_empty, 1'b1);

    wr(8'hA5);
    repeat (6) @(negedge clk);
    wr(8'h3C);              // R2 rejected mid-frame
    wait_idle();

    nine_bit <= 1'b1; tie <= 1'b0; tcie <= 1'b1;
    wr(8'h5A);              // R4 long frame
    @(negedge clk); nine_bit <= 1'b0;
    wait_idle();

    tx_en <= 1'b0;          // R7 pending and replace
    wr(8'h11); wr(8'h22);
    repeat (20) @(negedge clk);
    chk("R7 held while disabled", tx_empty, 1'b1);
    tx_en <= 1'b1;
    repeat (8) @(negedge clk);
    tx_en <= 1'b0;          // R9 finish but no further frame
    wait_idle();
    wr(8'h77);
    repeat (20) @(negedge clk);
    chk("R9 no new frame", tx_empty, 1'b1);
    tie <= 1'b1; tcie <= 1'b1;
    tx_en <= 1'b1;
    wait_idle();

    tick_div = 1;           // strobe every cycle, incl. start cycle
    wr(8'hC3);
    wait_idle();
    tick_div = 3; nine_bit <= 1'b1; tie <= 1'b0; tcie <= 1'b0;
    wr(8'h81);
    wait_idle();
    wr(8'h00); wr(8'hFF);   // second write lands while busy: R2
    wait_idle();
    repeat (5) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule